// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

While the system sits in hard reset, this block pulls configuration bytes out of a boot memory and assembles them into eight 32-bit configuration words. Each boot-memory access is one read at a strided address, and only the bottom byte lane of the returned data is kept. Every four bytes form one word, with the first byte as the most significant.

The first word belongs to the device that hosts the fetcher. It is held on `local_word`. From one prefix bit inside that word, the block derives the address of the reset exception vector. The remaining seven words are handed out one at a time to slave devices. Each goes out on a word bus together with a slave number and a one-cycle strobe.

When all 32 bytes have been taken, a done flag rises and the read request falls. Both stay that way until the next reset.

Top module: `cfgword_fetch`

## Requirements
- R1: While reset is low and in the first cycle after it, `rd_req` is 1, `rd_addr` is 0, `done` is 0, `slv_valid` is 0, `local_word` is 0 and `reset_vector` is 0x00000100.
- R2: A read is taken at a rising edge where `rd_req` and `rd_valid` are both 1. `rd_addr` starts at 0, grows by 8 after each taken read, and holds its value through wait states of any length.
- R3: Only `rd_data[7:0]` (byte lane 0) is used. All higher data bits have no effect on any output.
- R4: Taken bytes are grouped in fours. In each group, the first byte becomes bits 31:24 of the word and the fourth becomes bits 7:0.
- R5: The first word appears on `local_word` in the cycle after its fourth byte is taken. It then holds until reset.
- R6: Words two to eight appear on `slv_word`, in order, with `slv_idx` equal to 1 through 7. `slv_valid` is high for exactly one cycle, the cycle after the word's fourth byte is taken.
- R7: Exactly 32 reads are taken. `done` rises and `rd_req` falls in the cycle after the 32nd read. `done` then stays 1 until reset.
- R8: `rd_valid` has no effect while `rd_req` is 0. Address, words and strobes stay unchanged.
- R9: The reset vector base is 0x00000000 when bit `PREFIX_BIT` of `local_word` is 0, and 0xFFF00000 when it is 1. `reset_vector` is that base plus 0x100.
- R10: A reset applied partway through a fetch clears everything. The next fetch restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_req | output | 1 | Read request to boot memory |
| rd_addr | output | ADDR_W | Byte address of the current read |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | BUS_W | Read data; lane 0 is bits 7:0 |
| local_word | output | 32 | Configuration word for the local device |
| reset_vector | output | 32 | Reset exception vector address |
| slv_word | output | 32 | Configuration word for a slave |
| slv_idx | output | IDX_W | Slave number, 1 to 7 |
| slv_valid | output | 1 | One-cycle strobe for `slv_word` |
| done | output | 1 | All bytes fetched |

## Verification
The bench builds the fetcher with a 16-bit data port and the prefix bit moved to bit 30. This has two effects:
- The upper byte lane is driven with bytes that differ from lane 0, so any use of the wrong lane changes the assembled words.
- A prefix set only at the default bit 25 must leave the vector low, which separates the parameter from a fixed bit position.

Fetches run with zero, fixed and varying wait states, a reset lands in the middle of a fetch, and `rd_valid` is pulsed after completion.

// File: rtl/cfgword_fetch.sv
module cfgword_fetch #(
  parameter int          ADDR_W     = 16,
  parameter int          BUS_W      = 64,
  parameter int          STRIDE     = 8,
  parameter int          NUM_WORDS  = 8,
  parameter int          IDX_W      = $clog2(NUM_WORDS),
  parameter int          PREFIX_BIT = 25,
  parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [BUS_W-1:0]  rd_data,
  output logic [31:0]       local_word,
  output logic [31:0]       reset_vector,
  output logic [31:0]       slv_word,
  output logic [IDX_W-1:0]  slv_idx,
  output logic              slv_valid,
  output logic              done
);
  localparam int TOTAL = NUM_WORDS * 4;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt;
  logic [23:0]      acc;
  logic             fin;

  wire              take      = rd_req & rd_valid;
  wire [7:0]        lane      = rd_data[7:0];
  wire              unused_hi = ^rd_data;
  wire              word_end  = (cnt[1:0] == 2'b11);
  wire [IDX_W-1:0]  widx      = IDX_W'(cnt >> 2);
  wire [31:0]       word_now  = {acc, lane};
  wire [31:0]       vec_base  = local_word[PREFIX_BIT] ? HIGH_BASE : 32'h0;

  assign rd_req       = ~fin;
  assign done         = fin;
  assign rd_addr      = ADDR_W'(32'(cnt) * STRIDE);
  assign reset_vector = vec_base + VEC_OFFSET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      acc        <= '0;
      fin        <= 1'b0;
      local_word <= '0;
      slv_word   <= '0;
      slv_idx    <= '0;
      slv_valid  <= 1'b0;
    end else begin
      slv_valid <= 1'b0;
      if (take) begin
        cnt <= cnt + 1'b1;
        acc <= {acc[15:0], lane};
        if (word_end) begin
          if (widx == '0) begin
            local_word <= word_now;
          end else begin
            slv_word  <= word_now;
            slv_idx   <= widx;
            slv_valid <= 1'b1;
          end
        end
        if (cnt == CNT_W'(TOTAL - 1)) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgword_fetch_chk.sv
module cfgword_fetch_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [31:0]       local_word,
  input logic [IDX_W-1:0]  slv_idx,
  input logic              slv_valid,
  input logic              done
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> $stable(rd_addr));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (rd_addr == $past(rd_addr) + ADDR_W'(8)));

  p_slv_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slv_valid |=> !slv_valid);

  p_slv_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slv_valid |-> (slv_idx != '0));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_req_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  p_quiet_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(local_word) && !slv_valid && $stable(rd_addr)));
endmodule

bind cfgword_fetch cfgword_fetch_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .local_word(local_word), .slv_idx(slv_idx),
  .slv_valid(slv_valid), .done(done)
);

// File: tb/cfgword_fetch_bench.sv
module cfgword_fetch_bench;
  localparam int ADDR_W = 16;
  localparam int BUS_W  = 16;
  localparam int IDX_W  = 3;
  localparam int PB     = 30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_req, rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic [BUS_W-1:0]  rd_data = '0;
  logic [31:0]       local_word, reset_vector, slv_word;
  logic [IDX_W-1:0]  slv_idx;
  logic              slv_valid, done;

  int nchk = 0, nfail = 0;
  logic [31:0] words [8];

  always #5 clk = ~clk;

  cfgword_fetch #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .PREFIX_BIT(PB)) u_cfgword_fetch (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .local_word(local_word),
    .reset_vector(reset_vector), .slv_word(slv_word), .slv_idx(slv_idx),
    .slv_valid(slv_valid), .done(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(int n);
    return 8'(words[n / 4] >> (24 - 8 * (n % 4)));
  endfunction

  task automatic load(logic [31:0] seed, logic [31:0] w0);
    words[0] = w0;
    for (int i = 1; i < 8; i++) words[i] = seed ^ (32'h1020_3040 * i) ^ (i << 28);
  endtask

  task automatic do_reset();
    rd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 req in reset", rd_req, 1);
    chk("R1 addr in reset", rd_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 slv_valid", slv_valid, 0);
    chk("R1 local", local_word, 0);
    chk("R1 vector", reset_vector, 32'h100);
  endtask

  // waits: fixed gap; varw: gap varies per byte; stop: abort after that many bytes
  task automatic run_fetch(int waits, bit varw, int stop);
    int wc = 0, nb = 0, ns = 0;
    logic [ADDR_W-1:0] ea = '0;
    forever begin
      @(negedge clk);
      if (slv_valid) begin
        ns++;
        chk("R6 slave index", 32'(slv_idx), ns);
        chk("R6 slave word R4", slv_word, words[ns]);
      end
      if (nb == 32 && rd_valid) begin
        chk("R7 done rises", done, 1);
        chk("R7 req falls", rd_req, 0);
        break;
      end
      if (nb == stop && rd_valid) break;
      if (done) begin
        chk("R7 early done", done, 0);
        break;
      end
      if (wc > 0) begin
        rd_valid = 1'b0;
        rd_data = 16'hFFFF;
        wc--;
      end else begin
        chk("R2 address", 32'(rd_addr), 32'(ea));
        rd_valid = 1'b1;
        rd_data = {~byte_at(nb) ^ 8'(nb), byte_at(nb)};   // R3 upper lane differs
        nb++;
        ea += ADDR_W'(8);
        wc = varw ? (nb % 5) : waits;
      end
    end
    rd_valid = 1'b0;
    if (stop < 0) begin
      chk("R6 slave count", ns, 7);
      chk("R5 local word R4", local_word, words[0]);
    end
  endtask

  task automatic t_plain();
    load(32'h5A3C_96E1, 32'h0123_4567);
    do_reset();
    run_fetch(0, 0, -1);
    chk("R9 vector low", reset_vector, 32'h0000_0100);
  endtask

  task automatic t_waits_prefix();
    load(32'hC001_D00D, 32'h4000_00A5);
    do_reset();
    run_fetch(3, 0, -1);
    chk("R9 vector high", reset_vector, 32'hFFF0_0100);
  endtask

  task automatic t_var_waits();
    load(32'h0BAD_F00D, 32'hBEEF_0000 & ~(32'h1 << PB) | 32'h0200_0000);
    do_reset();
    run_fetch(0, 1, -1);
    chk("R9 other bit no effect", reset_vector, 32'h0000_0100);
  endtask

  task automatic t_after_done();
    logic [31:0] lw;
    lw = local_word;
    for (int i = 0; i < 3; i++) begin
      rd_valid = 1'b1;
      rd_data = 16'h7E81;
      @(negedge clk);
      chk("R8 no strobe", slv_valid, 0);
    end
    rd_valid = 1'b0;
    @(negedge clk);
    chk("R8 local held", local_word, lw);
    chk("R8 addr held", 32'(rd_addr), 256);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 done sticky", done, 1);
    end
  endtask

  task automatic t_mid_reset();
    load(32'h1357_9BDF, 32'h4242_4242);
    do_reset();
    run_fetch(1, 0, 10);
    do_reset();
    chk("R10 addr restart", 32'(rd_addr), 0);
    chk("R10 local cleared", local_word, 0);
    load(32'h2468_ACE0, 32'h0000_0001);
    run_fetch(2, 0, -1);
    chk("R10 vector after restart", reset_vector, 32'h100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_plain();
    t_after_done();
    t_waits_prefix();
    t_var_waits();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule